// File: doc/BRIEF.md
# Dual-Width Barrel Shifter with Illegal-Shift Trap

This block is the shift unit of an integer datapath whose register width can be switched between a full 64-bit mode and a narrow 32-bit mode. It is purely combinational. It takes the source operand, a shift amount (a register value or an immediate), a four-bit operation code and the mode bit. It returns the register-width result and a flag that marks the operation as an illegal instruction.

Three shift kinds are supported: logical left, logical right and arithmetic right. Each comes in four forms: register amount, immediate amount, word register amount and word immediate amount. The width mode picks both the amount mask and the sign extension of the result. Two cases raise the trap: a word form in 32-bit mode, and an immediate in 32-bit mode whose amount needs six bits. In both cases the result is forced to zero, so no write-back value leaks out.

Inside, the amount goes through a log-depth mux network that only shifts right. A left shift reverses the operand before the network and reverses the result after it.

Top module: `dualwidth_shifter`

## Requirements
- R1: The operation code `op_i[1:0]` selects the kind: 0 is logical left, 1 is logical right, 2 is arithmetic right, and 3 is reserved and always raises `illegal_o`. `op_i[3:2]` selects the form: 0 is register amount, 1 is immediate, 2 is word register amount, 3 is word immediate. `mode64_i`=1 selects 64-bit mode.
- R2: In 64-bit mode, register and immediate forms shift all 64 bits by `amt_i[5:0]` and ignore the higher amount bits. Immediates never trap in this mode.
- R3: In 32-bit mode, a register-amount shift uses only `amt_i[4:0]`.
- R4: In 32-bit mode, a logical right shift zero-extends bits 31:0 of the operand, shifts them, and sign-extends bit 31 of the shifted value into bits 63:32.
- R5: In 32-bit mode, left and arithmetic right shifts act on bits 31:0, the arithmetic fill is operand bit 31, and the result is sign-extended from bit 31. Operand bits 63:32 have no effect.
- R6: In 32-bit mode, an immediate form with `amt_i[5]`=1 raises `illegal_o`. With `amt_i[5]`=0 there is no trap, the shift uses `amt_i[4:0]`, and bits above 5 are ignored.
- R7: In 64-bit mode, word forms mask the amount to `amt_i[4:0]`, act on bits 31:0 as in R4 and R5, and sign-extend bit 31 of the result.
- R8: In 32-bit mode, every word form raises `illegal_o`.
- R9: Whenever `illegal_o` is 1, `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Source operand |
| amt_i | input | 64 | Shift amount: register value, or immediate in the low bits |
| op_i | input | 4 | Form in bits 3:2, kind in bits 1:0 |
| mode64_i | input | 1 | 1 for 64-bit mode, 0 for 32-bit mode |
| res_o | output | 64 | Shift result, zero when illegal |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The hardest cases to reach are those where bits the narrow paths should ignore still hold live values. Examples are an operand with garbage in bits 63:32 under a 32-bit arithmetic or logical right shift, and amounts with bit 5 or higher bits set under forms that mask them. The vector table places such patterns on purpose: upper-half ones under a logical right shift, a cleared bit 31 under upper-half ones for the arithmetic fill, and amounts like 0x21, 0x24 and 0x41F. Each of these gives a different answer if a mask or a fill source is wrong. Sweeps over every amount for a 64-bit left shift and a 32-bit arithmetic right shift then cover each stage of the mux network.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    KIND_SLL = 2'd0,
    KIND_SRL = 2'd1,
    KIND_SRA = 2'd2,
    KIND_RSV = 2'd3
  } shf_kind_e;

  typedef enum logic [1:0] {
    FORM_REG  = 2'd0,
    FORM_IMM  = 2'd1,
    FORM_WREG = 2'd2,
    FORM_WIMM = 2'd3
  } shf_form_e;

  localparam int OP_W = 4;

endpackage

// File: rtl/shf_amount_ctl.sv
module shf_amount_ctl
  import shf_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] amt_i,
  input  shf_form_e       form_i,
  input  shf_kind_e       kind_i,
  input  logic            mode64_i,
  output logic [SHW-1:0]  amt_o,
  output logic            narrow_o,
  output logic            trap_o
);

  logic is_word;
  logic is_imm;
  logic imm_too_big;

  always_comb begin
    is_word     = (form_i == FORM_WREG) || (form_i == FORM_WIMM);
    is_imm      = (form_i == FORM_IMM);
    narrow_o    = is_word || !mode64_i;
    imm_too_big = is_imm && !mode64_i && amt_i[SHW-1];
    trap_o      = (kind_i == KIND_RSV) || (is_word && !mode64_i) || imm_too_big;
    if (narrow_o) begin
      amt_o = {1'b0, amt_i[SHW-2:0]};
    end else begin
      amt_o = amt_i[SHW-1:0];
    end
  end

  always_comb begin
    if (!$isunknown({form_i, mode64_i, amt_i[SHW-1:0]})) begin
      // R6
      narrow_imm_trap_chk: assert (!(form_i == FORM_IMM && !mode64_i && amt_i[SHW-1]) || trap_o)
        else $error("narrow immediate with top amount bit did not trap");
      // R3
      narrow_amt_mask_chk: assert (!narrow_o || !amt_o[SHW-1])
        else $error("narrow shift amount exceeds half width");
    end
  end

endmodule

// File: rtl/shf_operand_prep.sv
module shf_operand_prep
  import shf_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] opnd_i,
  input  shf_kind_e       kind_i,
  input  logic            narrow_i,
  output logic [XLEN-1:0] data_o,
  output logic            fill_o,
  output logic            left_o
);

  logic [XLEN-1:0] widened;
  logic [XLEN-1:0] reversed;

  always_comb begin
    widened = opnd_i;
    if (narrow_i) begin
      if (kind_i == KIND_SRA) begin
        widened = {{HALF{opnd_i[HALF-1]}}, opnd_i[HALF-1:0]};
      end else if (kind_i == KIND_SRL) begin
        widened = {{HALF{1'b0}}, opnd_i[HALF-1:0]};
      end
    end
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign reversed[i] = widened[XLEN-1-i];
  end

  always_comb begin
    left_o = (kind_i == KIND_SLL);
    fill_o = (kind_i == KIND_SRA) ? widened[XLEN-1] : 1'b0;
    data_o = left_o ? reversed : widened;
  end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            fill_i,
  output logic [XLEN-1:0] data_o
);

  logic [XLEN-1:0] stage [SHW+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{STEP{fill_i}}, stage[s][XLEN-1:STEP]} : stage[s];
  end

  assign data_o = stage[SHW];

  always_comb begin
    if (!$isunknown({data_i, amt_i})) begin
      // R2
      zero_amt_identity_chk: assert (amt_i != '0 || data_o == data_i)
        else $error("zero amount altered data");
    end
  end

endmodule

// File: rtl/shf_result_fmt.sv
module shf_result_fmt #(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic            left_i,
  input  logic            narrow_i,
  input  logic            trap_i,
  output logic [XLEN-1:0] res_o
);

  logic [XLEN-1:0] unrev;
  logic [XLEN-1:0] oriented;

  for (genvar i = 0; i < XLEN; i++) begin : g_unrev
    assign unrev[i] = raw_i[XLEN-1-i];
  end

  always_comb begin
    oriented = left_i ? unrev : raw_i;
    if (trap_i) begin
      res_o = '0;
    end else if (narrow_i) begin
      res_o = {{HALF{oriented[HALF-1]}}, oriented[HALF-1:0]};
    end else begin
      res_o = oriented;
    end
  end

endmodule

// File: rtl/dualwidth_shifter.sv
module dualwidth_shifter
  import shf_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW  = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] opnd_i,
  input  logic [XLEN-1:0] amt_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            mode64_i,
  output logic [XLEN-1:0] res_o,
  output logic            illegal_o
);

  shf_kind_e       kind;
  shf_form_e       form;
  logic [SHW-1:0]  eff_amt;
  logic            narrow;
  logic            trap;
  logic [XLEN-1:0] prep_data;
  logic            fill;
  logic            is_left;
  logic [XLEN-1:0] shifted;

  assign kind = shf_kind_e'(op_i[1:0]);
  assign form = shf_form_e'(op_i[3:2]);

  shf_amount_ctl #(.XLEN(XLEN)) u_amt (
    .amt_i    (amt_i),
    .form_i   (form),
    .kind_i   (kind),
    .mode64_i (mode64_i),
    .amt_o    (eff_amt),
    .narrow_o (narrow),
    .trap_o   (trap)
  );

  shf_operand_prep #(.XLEN(XLEN)) u_prep (
    .opnd_i   (opnd_i),
    .kind_i   (kind),
    .narrow_i (narrow),
    .data_o   (prep_data),
    .fill_o   (fill),
    .left_o   (is_left)
  );

  shf_barrel #(.XLEN(XLEN)) u_barrel (
    .data_i (prep_data),
    .amt_i  (eff_amt),
    .fill_i (fill),
    .data_o (shifted)
  );

  shf_result_fmt #(.XLEN(XLEN)) u_fmt (
    .raw_i    (shifted),
    .left_i   (is_left),
    .narrow_i (narrow),
    .trap_i   (trap),
    .res_o    (res_o)
  );

  assign illegal_o = trap;

  always_comb begin
    if (!$isunknown({opnd_i, amt_i, op_i, mode64_i})) begin
      // R9
      zero_on_trap_chk: assert (!illegal_o || res_o == '0)
        else $error("illegal operation produced a nonzero result");
      // R8
      word_in_narrow_mode_chk: assert (!(op_i[3] && !mode64_i) || illegal_o)
        else $error("word form in 32-bit mode did not trap");
      // R1
      reserved_kind_chk: assert (op_i[1:0] != 2'd3 || illegal_o)
        else $error("reserved kind did not trap");
      // R5
      narrow_sext_chk: assert (illegal_o || (mode64_i && !op_i[3])
                               || res_o[XLEN-1:HALF] == {HALF{res_o[HALF-1]}})
        else $error("narrow result not sign-extended");
      // R2
      wide_imm_no_trap_chk: assert (!(mode64_i && op_i[3:2] == 2'd1 && op_i[1:0] != 2'd3)
                                    || !illegal_o)
        else $error("64-bit immediate trapped");
    end
  end

endmodule

// File: tb/sim_dualwidth_shifter.sv
module sim_dualwidth_shifter;

  typedef struct packed {
    logic [3:0]  op;
    logic        m64;
    logic [63:0] opnd;
    logic [63:0] amt;
    logic [63:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VEC [NVEC] = '{
    // R2: 64-bit register and immediate forms
    '{4'h0, 1'b1, 64'h1,                   64'h3F,  64'h8000_0000_0000_0000, 1'b0, 4'd2},
    '{4'h0, 1'b1, 64'h1,                   64'h40,  64'h1,                   1'b0, 4'd2},
    '{4'h1, 1'b1, 64'h8000_0000_0000_0000, 64'd63,  64'h1,                   1'b0, 4'd2},
    '{4'h2, 1'b1, 64'h8000_0000_0000_0000, 64'd4,   64'hF800_0000_0000_0000, 1'b0, 4'd2},
    '{4'h6, 1'b1, 64'hF000_0000_0000_0000, 64'h24,  64'hFFFF_FFFF_FF00_0000, 1'b0, 4'd2},
    '{4'h4, 1'b1, 64'h1234,                64'h20,  64'h0000_1234_0000_0000, 1'b0, 4'd2},
    '{4'h1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,   64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd2},
    // R3: 32-bit register amount masked to five bits
    '{4'h0, 1'b0, 64'h1,                   64'h21,  64'h2,                   1'b0, 4'd3},
    // R5: 32-bit left and arithmetic right
    '{4'h0, 1'b0, 64'h4000_0000,           64'd1,   64'hFFFF_FFFF_8000_0000, 1'b0, 4'd5},
    '{4'h2, 1'b0, 64'h0000_0000_8000_0000, 64'd8,   64'hFFFF_FFFF_FF80_0000, 1'b0, 4'd5},
    '{4'h2, 1'b0, 64'hFFFF_FFFF_7000_0000, 64'd4,   64'h0000_0000_0700_0000, 1'b0, 4'd5},
    // R4: 32-bit logical right
    '{4'h1, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd4,   64'h0000_0000_0800_0000, 1'b0, 4'd4},
    '{4'h1, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd0,   64'hFFFF_FFFF_8000_0000, 1'b0, 4'd4},
    // R6: 32-bit immediates
    '{4'h4, 1'b0, 64'h1,                   64'h20,  64'h0,                   1'b1, 4'd6},
    '{4'h6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3F,  64'h0,                   1'b1, 4'd6},
    '{4'h5, 1'b0, 64'h8000_0000,           64'h41F, 64'h1,                   1'b0, 4'd6},
    // R7: word forms in 64-bit mode
    '{4'h8, 1'b1, 64'h1,                   64'h3F,  64'hFFFF_FFFF_8000_0000, 1'b0, 4'd7},
    '{4'h9, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h24,  64'h0000_0000_0FFF_FFFF, 1'b0, 4'd7},
    '{4'hA, 1'b1, 64'h0000_0000_8000_0000, 64'd31,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd7},
    '{4'hD, 1'b1, 64'h8000_0000,           64'h20,  64'hFFFF_FFFF_8000_0000, 1'b0, 4'd7},
    // R8: word forms in 32-bit mode trap; R9 result zero
    '{4'hA, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'd3,   64'h0,                   1'b1, 4'd8},
    '{4'hC, 1'b0, 64'h1,                   64'd1,   64'h0,                   1'b1, 4'd8},
    // R1: reserved kind traps
    '{4'h3, 1'b1, 64'h5555,                64'd2,   64'h0,                   1'b1, 4'd1},
    '{4'h7, 1'b0, 64'h5555,                64'd2,   64'h0,                   1'b1, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opnd = '0;
  logic [63:0] amt = '0;
  logic [3:0]  op = '0;
  logic        m64 = 1'b0;
  logic [63:0] res;
  logic        ill;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dualwidth_shifter u0 (
    .opnd_i    (opnd),
    .amt_i     (amt),
    .op_i      (op),
    .mode64_i  (m64),
    .res_o     (res),
    .illegal_o (ill)
  );

  task automatic apply(input logic [3:0] o, input logic m, input logic [63:0] d, input logic [63:0] a);
    @(posedge clk);
    op = o; m64 = m; opnd = d; amt = a;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got_r, input logic got_i,
                       input logic [63:0] exp_r, input logic exp_i);
    n_run++;
    if (got_r !== exp_r || got_i !== exp_i) begin
      n_fail++;
      $display("FAIL %s: res=%h ill=%b expected res=%h ill=%b", tag, got_r, got_i, exp_r, exp_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state after reset: zero inputs give zero result, no trap (R2, R9)
    check("R2 idle", res, ill, 64'h0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].op, VEC[i].m64, VEC[i].opnd, VEC[i].amt);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), res, ill, VEC[i].exp, VEC[i].ill);
    end

    // R2: every amount of a 64-bit left shift
    for (int k = 0; k < 64; k++) begin
      apply(4'h0, 1'b1, 64'h1, 64'(k));
      check($sformatf("R2 sll k=%0d", k), res, ill, 64'h1 << k, 1'b0);
    end

    // R5: every amount of a 32-bit arithmetic right shift, with upper garbage
    for (int k = 0; k < 32; k++) begin
      logic signed [31:0] w;
      w = $signed(32'h8000_0000) >>> k;
      apply(4'h2, 1'b0, 64'h1234_5678_8000_0000, 64'(k));
      check($sformatf("R5 sra k=%0d", k), res, ill, {{32{w[31]}}, w}, 1'b0);
    end

    // R3: high amount bits are ignored for a 32-bit register shift
    apply(4'h1, 1'b0, 64'h0000_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FFE4);
    check("R3 high amount bits", res, ill, 64'h10, 1'b0);

    // R9: a trapping operation after a nonzero result clears the output
    apply(4'h0, 1'b1, 64'hFF, 64'd8);
    check("R9 pre", res, ill, 64'hFF00, 1'b0);
    apply(4'h4, 1'b0, 64'hFF, 64'h28);
    check("R9 trap zero", res, ill, 64'h0, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule